// File: doc/BRIEF.md
# Mode-Banked Processor Register File

A 32-bit register file for a small RISC core in which the set of physical registers seen through the logical register numbers 0 to 15 depends on the processor mode. It holds 37 physical 32-bit words: 31 general registers and 6 status registers. Logical register 15 is the program counter. Registers 0 to 7 and the program counter are common to every mode. The fast interrupt mode has private copies of registers 8 to 14. The interrupt, supervisor, abort and undefined modes each have private copies of registers 13 and 14.

The core reads two operands through combinational ports and writes one result per cycle through a write port. The current mode is held inside the block. It changes on a mode-set strobe, or on an exception-entry strobe. The exception-entry strobe also copies the current status word into the saved status register of the mode being entered, on the same clock edge that switches the mode. Every mode except user owns one saved status register. Reads and writes of the saved status always address the saved status register of the current mode.

Top module: `banked_regfile`

## Requirements
- R1: After the active-low asynchronous reset, the mode is user (code 0) and every general, current-status and saved-status register reads zero.
- R2: Logical registers 0 to 7 and 15 name the same physical storage in every mode. A write in one mode is seen by reads in all modes.
- R3: In fast interrupt mode (code 1), logical registers 8 to 14 address seven private registers. All other modes share a single copy of registers 8 to 12.
- R4: The interrupt (2), supervisor (3), abort (4) and undefined (5) modes each own private copies of logical registers 13 and 14. In user mode, and in these four modes, registers 8 to 12 are the user copies.
- R5: Mode codes 0 to 5 are user, fast interrupt, interrupt, supervisor, abort and undefined. Loading code 6 or 7 selects user mode, and mode_o then reads 0.
- R6: A read of the register being written in the same cycle returns the old value. The new value is visible from the cycle after the rising edge.
- R7: A register write in the same cycle as a mode change is steered by the mode that is current before the edge.
- R8: A current-status write loads cpsr_o on the next rising edge.
- R9: On exc_entry_i, the mode becomes mode_i and the old current status is stored in that mode's saved status on the same edge. The exception capture wins over a saved-status write to the same slot.
- R10: spsr_o shows the saved status of the current mode, and spsr_we_i writes it. In user mode, spsr_o returns the current status and saved-status writes are ignored.
- R11: The two read ports decode their addresses independently and can return different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Target mode code for mode set or exception entry |
| mode_we_i | input | 1 | Load mode_i as the current mode |
| exc_entry_i | input | 1 | Enter mode mode_i and save current status into its saved slot |
| mode_o | output | 3 | Current mode code |
| raddr_a_i | input | 4 | Logical address, read port A |
| rdata_a_o | output | 32 | Read data, port A (combinational) |
| raddr_b_i | input | 4 | Logical address, read port B |
| rdata_b_o | output | 32 | Read data, port B (combinational) |
| we_i | input | 1 | Register write enable |
| waddr_i | input | 4 | Logical write address |
| wdata_i | input | 32 | Write data |
| cpsr_we_i | input | 1 | Current status write enable |
| cpsr_wdata_i | input | 32 | Current status write data |
| cpsr_o | output | 32 | Current status |
| spsr_we_i | input | 1 | Saved status write enable (current mode) |
| spsr_wdata_i | input | 32 | Saved status write data |
| spsr_o | output | 32 | Saved status of current mode, or current status in user mode |

## Verification
The properties expect the inputs to be driven to known values on every clock edge after reset. They do not place any other limit on the inputs: mode codes 6 and 7, writes and mode changes in the same cycle, and exception entry together with a saved-status write are all legal. The stimulus therefore changes the inputs only at the falling edge and includes these overlaps. It uses directed passes and then a long random run in which the illegal mode codes and simultaneous strobes occur often.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int NUM_LREG   = 16;
  localparam int LREG_W     = 4;
  localparam int NUM_PHYS   = 31;
  localparam int PHYS_W     = $clog2(NUM_PHYS);
  localparam int FIQ_BASE   = 16;
  localparam int PAIR_BASE  = 23;
  localparam int NUM_SAVED  = 5;
  localparam int MODE_W     = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 3'd0,
    MODE_FIQ = 3'd1,
    MODE_IRQ = 3'd2,
    MODE_SVC = 3'd3,
    MODE_ABT = 3'd4,
    MODE_UND = 3'd5
  } mode_e;
endpackage

// File: rtl/rf_bank_map.sv
module rf_bank_map
  import rf_pkg::*;
(
  input  mode_e                mode_i,
  input  logic [LREG_W-1:0]    lreg_i,
  output logic [PHYS_W-1:0]    preg_o
);
  always_comb begin
    preg_o = PHYS_W'(lreg_i);
    if (lreg_i >= 4'd8 && lreg_i != 4'd15) begin
      if (mode_i == MODE_FIQ) begin
        preg_o = PHYS_W'(FIQ_BASE) + PHYS_W'(lreg_i - 4'd8);
      end else if (lreg_i >= 4'd13 && mode_i != MODE_USR) begin
        // one pair per mode, irq first
        preg_o = PHYS_W'(PAIR_BASE) + PHYS_W'({mode_i - 3'd2, 1'b0})
               + PHYS_W'(lreg_i - 4'd13);
      end
    end
  end
endmodule

// File: rtl/rf_gpr_store.sv
module rf_gpr_store
  import rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PHYS_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PHYS_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [PHYS_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] mem_q [NUM_PHYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PHYS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/rf_status.sv
module rf_status
  import rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_e             cur_mode_i,
  input  mode_e             tgt_mode_i,
  input  logic              exc_entry_i,
  input  logic              cpsr_we_i,
  input  logic [DATA_W-1:0] cpsr_wdata_i,
  input  logic              spsr_we_i,
  input  logic [DATA_W-1:0] spsr_wdata_i,
  output logic [DATA_W-1:0] cpsr_o,
  output logic [DATA_W-1:0] spsr_o
);
  logic [DATA_W-1:0] cpsr_q;
  logic [DATA_W-1:0] spsr_q [NUM_SAVED];
  logic [MODE_W-1:0] cur_slot, tgt_slot;

  assign cur_slot = cur_mode_i - 3'd1;
  assign tgt_slot = tgt_mode_i - 3'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpsr_q <= '0;
    end else if (cpsr_we_i) begin
      cpsr_q <= cpsr_wdata_i;
    end
  end

  for (genvar s = 0; s < NUM_SAVED; s++) begin : g_saved
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        spsr_q[s] <= '0;
      end else if (exc_entry_i && tgt_mode_i != MODE_USR && tgt_slot == MODE_W'(s)) begin
        spsr_q[s] <= cpsr_q;
      end else if (spsr_we_i && cur_mode_i != MODE_USR && cur_slot == MODE_W'(s)) begin
        spsr_q[s] <= spsr_wdata_i;
      end
    end
  end

  assign cpsr_o = cpsr_q;
  assign spsr_o = (cur_mode_i == MODE_USR) ? cpsr_q : spsr_q[cur_slot];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              mode_we_i,
  input  logic              exc_entry_i,
  output logic [2:0]        mode_o,
  input  logic [3:0]        raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [3:0]        raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o,
  input  logic              we_i,
  input  logic [3:0]        waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cpsr_we_i,
  input  logic [DATA_W-1:0] cpsr_wdata_i,
  output logic [DATA_W-1:0] cpsr_o,
  input  logic              spsr_we_i,
  input  logic [DATA_W-1:0] spsr_wdata_i,
  output logic [DATA_W-1:0] spsr_o
);
  localparam int NUM_PORTS = 3;  // read A, read B, write

  mode_e mode_q, mode_tgt;
  logic [LREG_W-1:0] lreg [NUM_PORTS];
  logic [PHYS_W-1:0] preg [NUM_PORTS];

  // unknown codes fall back to user
  assign mode_tgt = (mode_i > 3'd5) ? MODE_USR : mode_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_USR;
    end else if (mode_we_i || exc_entry_i) begin
      mode_q <= mode_tgt;
    end
  end

  assign lreg[0] = raddr_a_i;
  assign lreg[1] = raddr_b_i;
  assign lreg[2] = waddr_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_map
    rf_bank_map u_map (
      .mode_i (mode_q),
      .lreg_i (lreg[p]),
      .preg_o (preg[p])
    );
  end

  rf_gpr_store #(.DATA_W(DATA_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .waddr_i   (preg[2]),
    .wdata_i   (wdata_i),
    .raddr_a_i (preg[0]),
    .rdata_a_o (rdata_a_o),
    .raddr_b_i (preg[1]),
    .rdata_b_o (rdata_b_o)
  );

  rf_status #(.DATA_W(DATA_W)) u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cur_mode_i   (mode_q),
    .tgt_mode_i   (mode_tgt),
    .exc_entry_i  (exc_entry_i),
    .cpsr_we_i    (cpsr_we_i),
    .cpsr_wdata_i (cpsr_wdata_i),
    .spsr_we_i    (spsr_we_i),
    .spsr_wdata_i (spsr_wdata_i),
    .cpsr_o       (cpsr_o),
    .spsr_o       (spsr_o)
  );

  assign mode_o = mode_q;
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        mode_i,
  input logic              mode_we_i,
  input logic              exc_entry_i,
  input logic [2:0]        mode_o,
  input logic [3:0]        raddr_a_i,
  input logic [DATA_W-1:0] rdata_a_o,
  input logic              we_i,
  input logic [3:0]        waddr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              cpsr_we_i,
  input logic [DATA_W-1:0] cpsr_wdata_i,
  input logic [DATA_W-1:0] cpsr_o,
  input logic [DATA_W-1:0] spsr_o
);
  // R5
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o <= 3'd5);

  // R5
  mode_fallback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i || exc_entry_i) && mode_i > 3'd5 |=> mode_o == 3'd0);

  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_we_i && !exc_entry_i |=> $stable(mode_o));

  // R2
  shared_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (waddr_i < 4'd8 || waddr_i == 4'd15)
    |=> (raddr_a_i != $past(waddr_i) || rdata_a_o == $past(wdata_i)));

  // R6
  read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i && !mode_we_i && !exc_entry_i
    |=> (!$stable(raddr_a_i) || $stable(rdata_a_o)));

  // R8
  cpsr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpsr_we_i |=> cpsr_o == $past(cpsr_wdata_i));

  // R9
  exc_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_entry_i && mode_i >= 3'd1 && mode_i <= 3'd5 |=> spsr_o == $past(cpsr_o));

  // R10
  user_spsr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 3'd0 |-> spsr_o == cpsr_o);
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .mode_we_i    (mode_we_i),
  .exc_entry_i  (exc_entry_i),
  .mode_o       (mode_o),
  .raddr_a_i    (raddr_a_i),
  .rdata_a_o    (rdata_a_o),
  .we_i         (we_i),
  .waddr_i      (waddr_i),
  .wdata_i      (wdata_i),
  .cpsr_we_i    (cpsr_we_i),
  .cpsr_wdata_i (cpsr_wdata_i),
  .cpsr_o       (cpsr_o),
  .spsr_o       (spsr_o)
);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  mode_i = '0;
  logic        mode_we_i = 1'b0, exc_entry_i = 1'b0;
  logic [2:0]  mode_o;
  logic [3:0]  raddr_a_i = '0, raddr_b_i = '0, waddr_i = '0;
  logic [31:0] rdata_a_o, rdata_b_o, wdata_i = '0;
  logic        we_i = 1'b0, cpsr_we_i = 1'b0, spsr_we_i = 1'b0;
  logic [31:0] cpsr_wdata_i = '0, cpsr_o, spsr_wdata_i = '0, spsr_o;

  always #2 clk_i = ~clk_i;

  banked_regfile u_dut (.*);

  int n_vec = 0, n_bad = 0, cycles = 0;
  string cur_tag = "";

  // reference state
  logic [31:0] m_reg [6][16];
  logic [31:0] m_cpsr;
  logic [31:0] m_spsr [6];
  int          m_mode;

  function automatic bit shares(int ma, int mb, int r);
    if (ma == mb || r < 8 || r == 15) return 1;
    return (r < 13 && ma != 1 && mb != 1);
  endfunction

  function automatic string read_tag(int r);
    if (cur_tag != "") return cur_tag;
    if (r < 8 || r == 15) return "R2";
    if (r < 13) return "R3";
    return "R4";
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int m = 0; m < 6; m++) begin
      for (int r = 0; r < 16; r++) m_reg[m][r] = '0;
      m_spsr[m] = '0;
    end
    m_cpsr = '0;
    m_mode = 0;
  endtask

  task automatic step();
    int tgt;
    logic [31:0] old_cpsr;
    #1;
    chk(read_tag(raddr_a_i), "rdata_a", rdata_a_o, m_reg[m_mode][raddr_a_i]);
    chk((cur_tag != "") ? cur_tag : "R11", "rdata_b", rdata_b_o, m_reg[m_mode][raddr_b_i]);
    chk((cur_tag != "") ? cur_tag : "R5", "mode", 32'(mode_o), 32'(m_mode));
    chk((cur_tag != "") ? cur_tag : "R8", "cpsr", cpsr_o, m_cpsr);
    chk((cur_tag != "") ? cur_tag : "R10", "spsr", spsr_o,
        (m_mode == 0) ? m_cpsr : m_spsr[m_mode]);
    @(posedge clk_i);
    tgt = (mode_i > 3'd5) ? 0 : int'(mode_i);
    old_cpsr = m_cpsr;
    if (we_i)
      for (int m = 0; m < 6; m++)
        if (shares(m_mode, m, int'(waddr_i))) m_reg[m][waddr_i] = wdata_i;
    if (spsr_we_i && m_mode != 0) m_spsr[m_mode] = spsr_wdata_i;
    if (exc_entry_i && tgt != 0) m_spsr[tgt] = old_cpsr;
    if (cpsr_we_i) m_cpsr = cpsr_wdata_i;
    if (exc_entry_i || mode_we_i) m_mode = tgt;
    cycles++;
    @(negedge clk_i);
  endtask

  task automatic idle();
    mode_we_i = 0; exc_entry_i = 0; we_i = 0; cpsr_we_i = 0; spsr_we_i = 0;
  endtask

  task automatic set_mode(int m);
    idle(); mode_i = 3'(m); mode_we_i = 1; step(); idle();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state across all addresses
    cur_tag = "R1";
    for (int r = 0; r < 16; r++) begin
      raddr_a_i = 4'(r); raddr_b_i = 4'(15 - r); step();
    end
    // fill every mode's view with distinct values (R2 R3 R4)
    cur_tag = "";
    for (int m = 0; m < 6; m++) begin
      set_mode(m);
      for (int r = 0; r < 16; r++) begin
        we_i = 1; waddr_i = 4'(r); wdata_i = {8'hA0 + 8'(m), 8'(r), 16'h5A5A};
        raddr_a_i = 4'(r); raddr_b_i = 4'((r + 3) % 16); step();
      end
      idle();
    end
    // readback of every mode view on both ports (R11)
    for (int m = 0; m < 6; m++) begin
      set_mode(m);
      for (int r = 0; r < 16; r++) begin
        raddr_a_i = 4'(r); raddr_b_i = 4'(15 - r); step();
      end
    end
    // R6: read of register under write returns old value
    cur_tag = "R6";
    set_mode(3);
    we_i = 1; waddr_i = 4'd13; wdata_i = 32'hDEAD_0013; raddr_a_i = 4'd13; raddr_b_i = 4'd13; step();
    idle(); step();
    // R7: write during mode change uses old mode
    cur_tag = "R7";
    we_i = 1; waddr_i = 4'd14; wdata_i = 32'hC0DE_0014; mode_i = 3'd1; mode_we_i = 1;
    raddr_a_i = 4'd14; step();
    idle(); step();
    set_mode(3); raddr_a_i = 4'd14; step();
    // R9: exception entry saves status, wins over saved-status write
    cur_tag = "R9";
    for (int m = 1; m < 6; m++) begin
      cpsr_we_i = 1; cpsr_wdata_i = 32'h1000_0000 + 32'(m); step(); idle();
      mode_i = 3'(m); exc_entry_i = 1; spsr_we_i = 1; spsr_wdata_i = 32'hBAD0_0000;
      cpsr_we_i = 1; cpsr_wdata_i = 32'h2000_0000 + 32'(m); step(); idle(); step();
    end
    // R10: saved-status write ignored in user mode, works in others
    cur_tag = "R10";
    set_mode(0);
    spsr_we_i = 1; spsr_wdata_i = 32'h7777_7777; step(); idle(); step();
    set_mode(2);
    spsr_we_i = 1; spsr_wdata_i = 32'h3333_2222; step(); idle(); step();
    // R5: unknown codes fall back to user
    cur_tag = "R5";
    set_mode(6); step();
    set_mode(4); mode_i = 3'd7; exc_entry_i = 1; step(); idle(); step();
    // random run
    cur_tag = "";
    for (int i = 0; i < 4000; i++) begin
      mode_i       = 3'($urandom_range(0, 7));
      mode_we_i    = ($urandom_range(0, 9) == 0);
      exc_entry_i  = ($urandom_range(0, 11) == 0);
      we_i         = $urandom_range(0, 1) != 0;
      waddr_i      = 4'($urandom);
      wdata_i      = $urandom;
      raddr_a_i    = ($urandom_range(0, 3) == 0) ? waddr_i : 4'($urandom);
      raddr_b_i    = 4'($urandom);
      cpsr_we_i    = ($urandom_range(0, 5) == 0);
      cpsr_wdata_i = $urandom;
      spsr_we_i    = ($urandom_range(0, 5) == 0);
      spsr_wdata_i = $urandom;
      step();
    end
    idle();
    step();
    finish_run();
  end
endmodule